// File: doc/BRIEF.md
# Double-Buffered Channel Code Latch Bank

This block holds the digital codes for a bank of reference channels. Each channel has two registers in series. A staging register is loaded by the serial control interface. A drive register feeds the converter. A code in the drive register stands for a level of code/1024 of full scale, so any 10-bit value from 0 to 1023 is legal.

Three policies move codes from the staging registers to the drive registers:
- An asynchronous transfer pin. While it is low, every write shows up on the output. While it is high, all outputs hold.
- A broadcast flag carried with a written word. It moves every channel at once, whatever the pin level.
- Resets, which bypass the transfer policy entirely.

The serial decoder in front of the block turns bus transactions into single-cycle write, reset and readback requests. The block turns those requests into the outputs the converters see.

Top module: `chan_latch_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, every staging and drive register becomes mid-scale 512. The synchronized transfer pin also restarts in the hold (high) state.
- R2: A `gc_reset` pulse sets every staging and drive register to 512 at that clock edge, whatever the transfer pin level.
- R3: A `cmd_rst_all` pulse sets every staging and drive register to 512 at that clock edge, whatever the transfer pin level.
- R4: A `cmd_rst_one` pulse sets only channel `cmd_chan` to 512, in both its staging and its drive register, whatever the pin level. Every other channel is untouched.
- R5: `xfer_n` passes through a two-flop synchronizer. A level applied before clock edge k takes effect at edge k+2. While the synchronized level is low, every drive register loads its staging register at each edge, so a write appears on its output at the edge that commits it.
- R6: While the synchronized `xfer_n` is high, writes without the broadcast flag change only staging registers. All `out_codes` stay constant.
- R7: When the synchronized `xfer_n` falls, all drive registers load their staging registers at the same edge.
- R8: A write with `wr_bcast` set loads every drive register from staging at the edge that commits the write, including the newly written code, even while `xfer_n` is high.
- R9: `rd_data` is combinational. It returns the staging register of channel `rd_chan` in bits 9..0, with bits 15..10 always 0.
- R10: Priority, highest first: `rst_n`, then `gc_reset` or `cmd_rst_all`, then `cmd_rst_one`, then the write. A write is dropped, broadcast flag included, in a cycle where a whole-bank reset fires. It is also dropped when `cmd_rst_one` targets its channel. A write to a different channel in the same cycle as `cmd_rst_one` still commits.
- R11: Output channel i occupies `out_codes[10*i+9 : 10*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| gc_reset | input | 1 | General-call reset pulse |
| cmd_rst_all | input | 1 | Bank-wide mid-scale command pulse |
| cmd_rst_one | input | 1 | Single-channel mid-scale command pulse |
| cmd_chan | input | 3 | Channel targeted by `cmd_rst_one` |
| wr_en | input | 1 | Write strobe, one cycle per committed word |
| wr_chan | input | 3 | Channel index of the write |
| wr_code | input | 10 | Code being written |
| wr_bcast | input | 1 | Broadcast-transfer flag carried with the word |
| xfer_n | input | 1 | Asynchronous transfer pin, low = transparent |
| rd_chan | input | 3 | Readback channel select |
| rd_data | output | 16 | Readback word, staging code zero-extended |
| out_codes | output | 80 | Drive-register codes, channel i at bits 10*i+9..10*i |

## Verification
The bench targets the following corner cases:
- **Synchronizer timing.** A design with one flop too few or too many shifts every transparent-mode output by a cycle.
- **Hold and release.** Writes made with the pin high must stay invisible on the outputs but visible on readback. On release, the bench checks that every channel moves in one edge, not just the last one written.
- **Broadcast writes and resets with the pin high.** A broadcast that copied the staging value from before the write would leave its own channel stale. A reset gated by the pin would leave old outputs in place.
- **Collision cycles.** Single-channel reset against a write to the same channel and to a different channel. A design with the priority inverted commits a word that should have been dropped.

// File: rtl/clb_pkg.sv
// Shared constants for the channel latch bank.
// Assumes codes are unsigned binary; mid-scale is the top bit alone.
package clb_pkg;
    localparam int CLB_NCH = 8;   // channel count
    localparam int CLB_CW  = 10;  // code width
    localparam int CLB_RDW = 16;  // readback word width
endpackage

// File: rtl/clb_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes the input is a slow level; the reset value is the safe (hold) level.
module clb_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the sampled level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/clb_store.sv
// Staging register bank. Applies resets and writes by priority and
// exposes both the current contents and the next-edge contents.
// Assumes at most one write and one single-channel reset per cycle.
module clb_store #(
    parameter int NCH = 8,
    parameter int CW  = 10,
    localparam int IW = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_all,
    input  logic            clr_one,
    input  logic [IW-1:0]   clr_idx,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [CW-1:0]   wr_code,
    output logic            wr_take,
    output logic [NCH*CW-1:0] stor,
    output logic [NCH*CW-1:0] stor_nxt
);
    localparam logic [CW-1:0] MIDC = CW'(1) << (CW-1);

    // A write survives only when no reset claims its channel.
    assign wr_take = wr_en && !clr_all && !(clr_one && (clr_idx == wr_idx));

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit_clr, hit_wr;
        assign hit_clr = clr_all || (clr_one && (clr_idx == IW'(g)));
        assign hit_wr  = wr_take && (wr_idx == IW'(g));

        // Next staging value for this channel: reset first, then write.
        always_comb begin
            if (hit_clr)     stor_nxt[g*CW +: CW] = MIDC;
            else if (hit_wr) stor_nxt[g*CW +: CW] = wr_code;
            else             stor_nxt[g*CW +: CW] = stor[g*CW +: CW];
        end

        // Staging register, mid-scale after power-up reset.
        always_ff @(posedge clk) begin
            if (!rst_n) stor[g*CW +: CW] <= MIDC;
            else        stor[g*CW +: CW] <= stor_nxt[g*CW +: CW];
        end
    end
endmodule

// File: rtl/clb_out.sv
// Drive register bank. Loads every channel from next-staging on a
// transfer, and a single channel when a reset forces it.
// Assumes stor_nxt already carries reset values for cleared channels.
module clb_out #(
    parameter int NCH = 8,
    parameter int CW  = 10,
    localparam int IW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              clr_one,
    input  logic [IW-1:0]     clr_idx,
    input  logic              xfer,
    input  logic [NCH*CW-1:0] stor_nxt,
    output logic [NCH*CW-1:0] outq
);
    localparam logic [CW-1:0] MIDC = CW'(1) << (CW-1);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic load;
        assign load = xfer || clr_all || (clr_one && (clr_idx == IW'(g)));

        // Drive register: loads the next staging value when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)    outq[g*CW +: CW] <= MIDC;
            else if (load) outq[g*CW +: CW] <= stor_nxt[g*CW +: CW];
        end
    end
endmodule

// File: rtl/chan_latch_bank.sv
// Top of the double-buffered channel latch bank: staging registers,
// drive registers, transfer-pin synchronizer and readback mux.
// Assumes request pulses are single-cycle and already decoded.
module chan_latch_bank
    import clb_pkg::*;
#(
    parameter int NCH   = CLB_NCH,
    parameter int CW    = CLB_CW,
    parameter int RDW   = CLB_RDW,
    parameter int SYNCS = 2,
    localparam int IW   = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gc_reset,
    input  logic              cmd_rst_all,
    input  logic              cmd_rst_one,
    input  logic [IW-1:0]     cmd_chan,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_chan,
    input  logic [CW-1:0]     wr_code,
    input  logic              wr_bcast,
    input  logic              xfer_n,
    input  logic [IW-1:0]     rd_chan,
    output logic [RDW-1:0]    rd_data,
    output logic [NCH*CW-1:0] out_codes
);
    logic              lat_hold;
    logic              clr_all;
    logic              wr_take;
    logic              xfer;
    logic [NCH*CW-1:0] stor_flat;
    logic [NCH*CW-1:0] stor_nxt;

    assign clr_all = gc_reset || cmd_rst_all;

    clb_sync #(.STAGES(SYNCS), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(xfer_n), .dout(lat_hold)
    );

    clb_store #(.NCH(NCH), .CW(CW)) u_store (
        .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
        .clr_one(cmd_rst_one), .clr_idx(cmd_chan),
        .wr_en(wr_en), .wr_idx(wr_chan), .wr_code(wr_code),
        .wr_take(wr_take), .stor(stor_flat), .stor_nxt(stor_nxt)
    );

    // Whole-bank transfer: transparent pin level or an accepted broadcast word.
    assign xfer = !lat_hold || (wr_take && wr_bcast);

    clb_out #(.NCH(NCH), .CW(CW)) u_out (
        .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
        .clr_one(cmd_rst_one), .clr_idx(cmd_chan),
        .xfer(xfer), .stor_nxt(stor_nxt), .outq(out_codes)
    );

    // Readback of the staging code, zero-extended to the bus word.
    assign rd_data = RDW'(stor_flat[rd_chan*CW +: CW]);
endmodule

// File: rtl/clb_chk.sv
// Property checker for chan_latch_bank, attached by bind.
module clb_chk #(
    parameter int NCH = 8,
    parameter int CW  = 10,
    localparam int IW = $clog2(NCH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gc_reset,
    input logic              cmd_rst_all,
    input logic              cmd_rst_one,
    input logic [IW-1:0]     cmd_chan,
    input logic              wr_en,
    input logic              wr_bcast,
    input logic              lat_hold,
    input logic [NCH*CW-1:0] stor_flat,
    input logic [NCH*CW-1:0] out_codes
);
    localparam logic [CW-1:0]     MIDC = CW'(1) << (CW-1);
    localparam logic [NCH*CW-1:0] ALLMID = {NCH{MIDC}};

    logic bank_clr;
    assign bank_clr = gc_reset || cmd_rst_all;

    // R1
    pwrup_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (out_codes == ALLMID) && (stor_flat == ALLMID));

    // R2 R3
    bank_clr_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_clr |=> (out_codes == ALLMID) && (stor_flat == ALLMID));

    // R4
    one_clr_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rst_one && !bank_clr) |=> out_codes[$past(cmd_chan)*CW +: CW] == MIDC);

    // R5 R7
    transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lat_hold && !bank_clr) |=> out_codes == stor_flat);

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_hold && !(wr_en && wr_bcast) && !bank_clr && !cmd_rst_one)
        |=> $stable(out_codes));

    // R8
    bcast_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bcast && !bank_clr && !cmd_rst_one) |=> out_codes == stor_flat);
endmodule

bind chan_latch_bank clb_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .gc_reset(gc_reset), .cmd_rst_all(cmd_rst_all),
    .cmd_rst_one(cmd_rst_one), .cmd_chan(cmd_chan), .wr_en(wr_en),
    .wr_bcast(wr_bcast), .lat_hold(lat_hold), .stor_flat(stor_flat),
    .out_codes(out_codes)
);

// File: tb/tb_chan_latch_bank.sv
`timescale 1ns/1ps
module tb_chan_latch_bank;
    localparam int NCH = 8;
    localparam int CW  = 10;

    logic clk = 1'b0;
    logic rst_n, gc_reset, cmd_rst_all, cmd_rst_one, wr_en, wr_bcast, xfer_n;
    logic [2:0] cmd_chan, wr_chan, rd_chan;
    logic [9:0] wr_code;
    logic [15:0] rd_data;
    logic [79:0] out_codes;

    int vectors = 0, miscompares = 0;
    string cur_req = "R1";
    bit armed = 0;
    bit done = 0;

    // Reference model state
    int stor_m[NCH];
    int out_m[NCH];
    int s1, s2;

    always #2.5 clk = ~clk;

    chan_latch_bank dut (
        .clk(clk), .rst_n(rst_n), .gc_reset(gc_reset), .cmd_rst_all(cmd_rst_all),
        .cmd_rst_one(cmd_rst_one), .cmd_chan(cmd_chan), .wr_en(wr_en),
        .wr_chan(wr_chan), .wr_code(wr_code), .wr_bcast(wr_bcast),
        .xfer_n(xfer_n), .rd_chan(rd_chan), .rd_data(rd_data), .out_codes(out_codes)
    );

    // Behavioural model, advanced on each rising edge.
    always @(posedge clk) begin
        int sn[NCH];
        bit took, xf;
        armed = 1;
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin stor_m[i] = 512; out_m[i] = 512; end
            s1 = 1; s2 = 1;
        end else begin
            if (gc_reset || cmd_rst_all) begin
                for (int i = 0; i < NCH; i++) begin stor_m[i] = 512; out_m[i] = 512; end
            end else begin
                sn = stor_m;
                took = wr_en && !(cmd_rst_one && cmd_chan == wr_chan);
                if (cmd_rst_one) sn[cmd_chan] = 512;
                if (took) sn[wr_chan] = int'(wr_code);
                xf = (s2 == 0) || (took && wr_bcast);
                for (int i = 0; i < NCH; i++)
                    if (xf || (cmd_rst_one && cmd_chan == i)) out_m[i] = sn[i];
                stor_m = sn;
            end
            s2 = s1; s1 = int'(xfer_n);
        end
    end

    // Compare every cycle, well after the falling edge where inputs move.
    always @(negedge clk) begin
        #1;
        if (armed && !done) begin
            // R11: channel i at out_codes[10*i +: 10]
            for (int i = 0; i < NCH; i++) begin
                vectors++;
                if (int'(out_codes[i*CW +: CW]) != out_m[i]) begin
                    miscompares++;
                    $display("FAIL %s out ch%0d got %0d expected %0d", cur_req, i,
                             out_codes[i*CW +: CW], out_m[i]);
                end
            end
            vectors++;
            if (int'(rd_data) != stor_m[rd_chan]) begin
                miscompares++;
                $display("FAIL R9 rd_data ch%0d got %0d expected %0d", rd_chan,
                         rd_data, stor_m[rd_chan]);
            end
        end
    end

    task automatic idle();
        gc_reset = 0; cmd_rst_all = 0; cmd_rst_one = 0; wr_en = 0; wr_bcast = 0;
    endtask

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int ch, int code, bit bc);
        idle();
        wr_en = 1; wr_chan = 3'(ch); wr_code = 10'(code); wr_bcast = bc;
        rd_chan = 3'(ch);
        tick();
        idle();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog expired got hang expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0; xfer_n = 1; cmd_chan = 0; wr_chan = 0; wr_code = 0; rd_chan = 0;
        cur_req = "R1";
        tick(3);
        rst_n = 1;
        tick(2);

        // R6: pin high, writes reach staging only
        cur_req = "R6";
        for (int i = 0; i < NCH; i++) wr(i, 100 + 37 * i, 0);
        tick(3);

        // R7: falling pin moves every channel in one edge (two-flop delay, R5)
        cur_req = "R7";
        xfer_n = 0;
        tick(4);

        // R5: transparent writes, extremes of code range
        cur_req = "R5";
        wr(2, 0, 0);
        wr(3, 1023, 0);
        wr(4, 511, 0);
        tick(2);

        // R8: broadcast with pin high, includes the new word
        cur_req = "R8";
        xfer_n = 1;
        tick(3);
        wr(0, 7, 0);
        wr(5, 900, 0);
        wr(6, 33, 1);
        tick(2);

        // R2: general call with pin high
        cur_req = "R2";
        wr(1, 222, 0);
        gc_reset = 1; tick(); idle();
        tick(2);

        // R3: bank command with pin high
        cur_req = "R3";
        wr(7, 1, 1);
        cmd_rst_all = 1; tick(); idle();
        tick();

        // R4 / R10: single-channel reset, collisions
        cur_req = "R4";
        wr(3, 444, 1);
        wr(4, 555, 1);
        cmd_rst_one = 1; cmd_chan = 3; tick(); idle();
        cur_req = "R10";
        cmd_rst_one = 1; cmd_chan = 4; wr_en = 1; wr_chan = 4; wr_code = 10'd9;
        wr_bcast = 1; rd_chan = 4; tick(); idle();
        cmd_rst_one = 1; cmd_chan = 5; wr_en = 1; wr_chan = 6; wr_code = 10'd66;
        wr_bcast = 0; rd_chan = 6; tick(); idle();
        cmd_rst_all = 1; wr_en = 1; wr_chan = 2; wr_code = 10'd77; wr_bcast = 1;
        tick(); idle();
        tick(2);

        // R9 and mixed random traffic
        cur_req = "R9";
        for (int i = 0; i < NCH; i++) begin rd_chan = 3'(i); tick(); end
        cur_req = "R10";
        for (int k = 0; k < 3000; k++) begin
            idle();
            wr_en = ($urandom_range(0, 2) != 0);
            wr_chan = 3'($urandom_range(0, 7));
            wr_code = 10'($urandom_range(0, 1023));
            wr_bcast = ($urandom_range(0, 7) == 0);
            cmd_rst_one = ($urandom_range(0, 15) == 0);
            cmd_chan = 3'($urandom_range(0, 7));
            cmd_rst_all = ($urandom_range(0, 63) == 0);
            gc_reset = ($urandom_range(0, 63) == 0);
            rd_chan = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 9) == 0) xfer_n = ~xfer_n;
            if ($urandom_range(0, 499) == 0) rst_n = 0; else rst_n = 1;
            tick();
        end
        idle(); rst_n = 1;
        tick(3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule